// File: doc/BRIEF.md
# Direct Digital Synthesis Sine Generator

This block is a numerically controlled oscillator with a sine output. A 48-bit phase register advances by a programmable step on every clock and wraps modulo 2^48. The output frequency is therefore the step divided by 2^48, times the clock rate. The upper bits of the phase form a short table index, and the lower bits are dropped. The block turns that index into a signed 14-bit amplitude sample on every cycle.

Only one quadrant of the sine is stored, and the values are fixed when the design is elaborated. The top phase bit gives the sign, and the bit below it mirrors the quadrant address, so the full period is rebuilt from the single stored quadrant. A new step value is captured with a load strobe and never disturbs the running phase, so frequency changes are phase-continuous.

The raw phase is brought out for observation. A valid flag marks the samples that come from real table reads.

Top module: `dds_sine_gen`

## Requirements
- R1: While the synchronous reset is sampled high, the phase clears to zero, the active step clears to zero, the valid flag goes low and the sample goes to 0. All of these are visible after that clock edge.
- R2: On every clock edge outside reset, `phase_out` becomes its previous value plus the active step, modulo 2^48.
- R3: When `tw_load` is high at an edge, `tw_in` becomes the active step from that edge on. The first phase advance that uses it happens at the following edge. The phase itself is not reset.
- R4: When `tw_load` is low, a change on `tw_in` has no effect on the phase progression.
- R5: `amp_valid` is low for the first clock edge after reset release and high from the second edge onward. The sample shown at an edge belongs to the phase value that was visible two edges earlier.
- R6: Let k be phase bits [47:36], the 12-bit truncated phase. The sample equals round(8191 * sin(2*pi*(k+0.5)/4096)), within one LSB.
- R7: The sample is negative exactly when phase bit 47 was set, two edges earlier. Because of the half-step offset in R6, the sample is never zero while valid.
- R8: When phase bit 46 is set, the quadrant address is bit-inverted, so the mirrored quadrant matches R6. The sample never takes the value -8192.
- R9: Phase bits [35:0] do not affect the sample. Two valid samples whose source phases share bits [47:36] are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tw_load | input | 1 | Strobe that captures `tw_in` as the active step |
| tw_in | input | 48 | Tuning step, unsigned |
| amp_out | output | 14 | Signed sine sample, two's complement |
| amp_valid | output | 1 | Sample is from a completed table read |
| phase_out | output | 48 | Current phase register value |

## Verification
Two kinds of fault in the phase register or the active step become visible on `phase_out` at the very next edge. One is a wrong accumulator carry; the other is a step that is captured early or late. The sample then goes wrong two edges later. A fault in the table, the address fold or the sign path changes no phase value, but it corrupts the sample in the same cycle its phase leaves the pipeline. A wrong mirror bit shows only while phase bit 46 is set, and a sign fault shows only in the second half-cycle. A pipeline depth that is off by one shows as a valid flag rising one edge early or late, and as every sample being shifted by one phase step.

// File: rtl/dds_pkg.sv
package dds_pkg;

  // Fold a truncated phase index into a quarter-table address.
  // Bit QW-1 of the index is the sign, bit QW-2 the mirror select.
  function automatic int unsigned fold_addr(input int unsigned idx, input int unsigned qw);
    int unsigned low_mask;
    int unsigned low;
    low_mask = (32'd1 << (qw - 2)) - 1;
    low      = idx & low_mask;
    if (((idx >> (qw - 2)) & 1) != 0) begin
      fold_addr = low_mask - low;
    end else begin
      fold_addr = low;
    end
  endfunction

  // Sign bit for a truncated phase index.
  function automatic logic idx_negative(input int unsigned idx, input int unsigned qw);
    idx_negative = ((idx >> (qw - 1)) & 1) != 0;
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int PHASE_W = 48
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [PHASE_W-1:0] step_in,
  output logic [PHASE_W-1:0] step_q,
  output logic [PHASE_W-1:0] phase_q
);

  logic [PHASE_W-1:0] phase_next;

  // the adder carry out of the top bit is dropped: modulo 2^PHASE_W
  assign phase_next = phase_q + step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q  <= '0;
      phase_q <= '0;
    end else begin
      phase_q <= phase_next;
      if (load) begin
        step_q <= step_in;
      end
    end
  end

endmodule

// File: rtl/dds_quadrant_fold.sv
module dds_quadrant_fold #(
  parameter int PHASE_W = 48,
  parameter int TRUNC_W = 12
) (
  input  logic [PHASE_W-1:0] phase,
  output logic [TRUNC_W-1:0] idx,
  output logic [TRUNC_W-3:0] qaddr,
  output logic               neg
);

  localparam int QADDR_W = TRUNC_W - 2;

  logic mirror;
  logic [QADDR_W-1:0] raw_addr;

  assign idx      = phase[PHASE_W-1 -: TRUNC_W];
  assign neg      = idx[TRUNC_W-1];
  assign mirror   = idx[TRUNC_W-2];
  assign raw_addr = idx[QADDR_W-1:0];
  assign qaddr    = mirror ? ~raw_addr : raw_addr;

endmodule

// File: rtl/dds_quarter_rom.sv
module dds_quarter_rom #(
  parameter int QADDR_W = 10,
  parameter int MAG_W   = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [QADDR_W-1:0] addr,
  output logic [MAG_W-1:0]   mag_q
);

  localparam int  QDEPTH  = 1 << QADDR_W;
  localparam int  MAG_MAX = (1 << MAG_W) - 1;
  localparam real PI_R    = 3.14159265358979323846;

  logic [MAG_W-1:0] qtab [QDEPTH];

  // each entry samples the centre of its slot, so mirrored halves match exactly
  for (genvar i = 0; i < QDEPTH; i++) begin : g_entry
    localparam real ANG = (real'(i) + 0.5) * PI_R / (2.0 * real'(QDEPTH));
    localparam int  VAL = $rtoi(real'(MAG_MAX) * $sin(ANG) + 0.5);
    assign qtab[i] = VAL[MAG_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mag_q <= '0;
    end else begin
      mag_q <= qtab[addr];
    end
  end

endmodule

// File: rtl/dds_amp_stage.sv
module dds_amp_stage #(
  parameter int AMP_W = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [AMP_W-2:0]        mag,
  input  logic                    neg,
  input  logic                    in_valid,
  output logic signed [AMP_W-1:0] amp_q,
  output logic                    valid_q
);

  logic signed [AMP_W-1:0] pos_val;

  assign pos_val = signed'({1'b0, mag});

  always_ff @(posedge clk) begin
    if (rst) begin
      amp_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      amp_q   <= neg ? -pos_val : pos_val;
      valid_q <= in_valid;
    end
  end

endmodule

// File: rtl/dds_sine_gen.sv
module dds_sine_gen #(
  parameter int PHASE_W = 48,
  parameter int TRUNC_W = 12,
  parameter int AMP_W   = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tw_load,
  input  logic [PHASE_W-1:0]      tw_in,
  output logic signed [AMP_W-1:0] amp_out,
  output logic                    amp_valid,
  output logic [PHASE_W-1:0]      phase_out
);

  localparam int QADDR_W = TRUNC_W - 2;
  localparam int MAG_W   = AMP_W - 1;

  // named internal events for the checker
  logic [PHASE_W-1:0] ftw_cur;
  logic [PHASE_W-1:0] phase_cur;
  logic [TRUNC_W-1:0] trunc_idx;
  logic [QADDR_W-1:0] rom_addr;
  logic               neg_now;
  logic               neg_q;
  logic               rd_valid_q;
  logic [MAG_W-1:0]   rom_mag;

  dds_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .load    (tw_load),
    .step_in (tw_in),
    .step_q  (ftw_cur),
    .phase_q (phase_cur)
  );

  dds_quadrant_fold #(.PHASE_W(PHASE_W), .TRUNC_W(TRUNC_W)) u_fold (
    .phase (phase_cur),
    .idx   (trunc_idx),
    .qaddr (rom_addr),
    .neg   (neg_now)
  );

  dds_quarter_rom #(.QADDR_W(QADDR_W), .MAG_W(MAG_W)) u_rom (
    .clk   (clk),
    .rst   (rst),
    .addr  (rom_addr),
    .mag_q (rom_mag)
  );

  // the sign travels alongside the table read
  always_ff @(posedge clk) begin
    if (rst) begin
      neg_q      <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      neg_q      <= neg_now;
      rd_valid_q <= 1'b1;
    end
  end

  dds_amp_stage #(.AMP_W(AMP_W)) u_amp (
    .clk      (clk),
    .rst      (rst),
    .mag      (rom_mag),
    .neg      (neg_q),
    .in_valid (rd_valid_q),
    .amp_q    (amp_out),
    .valid_q  (amp_valid)
  );

  assign phase_out = phase_cur;

endmodule

// File: rtl/dds_sine_gen_chk.sv
module dds_sine_gen_chk #(
  parameter int PHASE_W = 48,
  parameter int TRUNC_W = 12,
  parameter int AMP_W   = 14
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    tw_load,
  input logic [PHASE_W-1:0]      tw_in,
  input logic [PHASE_W-1:0]      ftw_cur,
  input logic [PHASE_W-1:0]      phase_out,
  input logic signed [AMP_W-1:0] amp_out,
  input logic                    amp_valid
);

  localparam int LOW_W = PHASE_W - TRUNC_W;
  localparam logic signed [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

  // R1: reset clears state
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (phase_out == '0 && ftw_cur == '0 && !amp_valid && amp_out == '0));

  // R2: accumulate modulo 2^PHASE_W
  assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> phase_out == $past(phase_out) + $past(ftw_cur));

  // R3: load captures the new step
  assert_step_load_R3: assert property (@(posedge clk) disable iff (rst)
    tw_load |=> ftw_cur == $past(tw_in));

  // R4: no load keeps the step
  assert_step_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !tw_load |=> $stable(ftw_cur));

  // R5: valid low one edge after release, then high
  assert_valid_first_R5: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !amp_valid);
  assert_valid_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> amp_valid);

  // R7: sign follows top phase bit two edges back
  assert_sign_R7: assert property (@(posedge clk) disable iff (rst)
    amp_valid |-> (amp_out[AMP_W-1] == $past(phase_out[PHASE_W-1], 2) && amp_out != '0));

  // R8: symmetric range
  assert_no_most_neg_R8: assert property (@(posedge clk) disable iff (rst)
    amp_out != MOST_NEG);

  // R9: discarded phase bits do not move the sample
  assert_trunc_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (amp_valid && $past(amp_valid) &&
     ($past(phase_out, 2) >> LOW_W) == ($past(phase_out, 3) >> LOW_W)) |-> $stable(amp_out));

endmodule

bind dds_sine_gen dds_sine_gen_chk #(
  .PHASE_W(PHASE_W), .TRUNC_W(TRUNC_W), .AMP_W(AMP_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tw_load   (tw_load),
  .tw_in     (tw_in),
  .ftw_cur   (ftw_cur),
  .phase_out (phase_out),
  .amp_out   (amp_out),
  .amp_valid (amp_valid)
);

// File: tb/tb_dds_sine_gen.sv
module tb_dds_sine_gen;

  localparam int PW = 48;
  localparam int AW = 14;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 tw_load = 1'b0;
  logic [PW-1:0]        tw_in = '0;
  logic signed [AW-1:0] amp_out;
  logic                 amp_valid;
  logic [PW-1:0]        phase_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dds_sine_gen dut (
    .clk       (clk),
    .rst       (rst),
    .tw_load   (tw_load),
    .tw_in     (tw_in),
    .amp_out   (amp_out),
    .amp_valid (amp_valid),
    .phase_out (phase_out)
  );

  // reference sample computed from the truncated phase (R6)
  function automatic int ref_amp(input logic [PW-1:0] ph);
    real ang, s, mag;
    int  k;
    k   = int'(ph[47:36]);
    ang = 2.0 * 3.14159265358979323846 * (real'(k) + 0.5) / 4096.0;
    s   = $sin(ang);
    mag = (s < 0.0 ? -s : s) * 8191.0 + 0.5;
    ref_amp = (s < 0.0) ? -$rtoi(mag) : $rtoi(mag);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- scoreboard model and monitor ----------------
  logic [PW-1:0] m_phase = '0;
  logic [PW-1:0] m_ftw   = '0;
  int            m_cnt   = 0;
  bit            have_model = 1'b0;
  int            exp_q[$];
  logic [PW-1:0] src_q[$];

  always @(negedge clk) begin
    if (have_model) begin
      chk(phase_out == m_phase, "R2 R3 phase", longint'(phase_out), longint'(m_phase));
      if (m_cnt == 0) begin
        chk(amp_valid == 1'b0 && amp_out == 0 && phase_out == 0, "R1 reset state",
            longint'(amp_out), 0);
      end
      chk(amp_valid == (m_cnt >= 2), "R5 valid timing", longint'(amp_valid), longint'(m_cnt >= 2));
      if (amp_valid && exp_q.size() > 0) begin
        int e;
        int d;
        logic [PW-1:0] src;
        e   = exp_q.pop_front();
        src = src_q.pop_front();
        d   = int'(amp_out) - e;
        if (src[46]) chk(d >= -1 && d <= 1, "R8 mirrored quadrant", longint'(amp_out), longint'(e));
        else         chk(d >= -1 && d <= 1, "R6 sample value", longint'(amp_out), longint'(e));
        chk(amp_out[AW-1] == src[47] && amp_out != 0, "R7 sign", longint'(amp_out), longint'(e));
      end
    end
    // advance model to the value after the coming edge
    if (rst) begin
      m_phase = '0;
      m_ftw   = '0;
      m_cnt   = 0;
      exp_q.delete();
      src_q.delete();
      have_model = 1'b1;
    end else if (have_model) begin
      exp_q.push_back(ref_amp(m_phase));
      src_q.push_back(m_phase);
      m_phase = m_phase + m_ftw;
      if (tw_load) m_ftw = tw_in;
      if (m_cnt < 10) m_cnt++;
    end
  end

  // ---------------- driver tasks ----------------
  task automatic step_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset(input int n);
    rst = 1'b1;
    tw_load = 1'b0;
    step_cycles(n);
    rst = 1'b0;
  endtask

  task automatic load_tw(input logic [PW-1:0] v);
    tw_in   = v;
    tw_load = 1'b1;
    step_cycles(1);
    tw_load = 1'b0;
  endtask

  // R4: change tw_in without load, the step must not change
  task automatic check_no_load;
    logic [PW-1:0] p0, p1, old_step;
    old_step = m_ftw;
    tw_in = 48'h0123_4567_89AB;
    step_cycles(2);
    @(negedge clk); p0 = phase_out;
    @(negedge clk); p1 = phase_out;
    chk(p1 - p0 == old_step, "R4 step held without load", longint'(p1 - p0), longint'(old_step));
    @(posedge clk); #1;
  endtask

  // R9: small step keeps top bits fixed, sample must stay constant
  task automatic check_trunc;
    logic signed [AW-1:0] first;
    load_tw(48'd1000);
    step_cycles(4);
    @(negedge clk); first = amp_out;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(amp_out == first, "R9 low bits ignored", longint'(amp_out), longint'(first));
    end
    @(posedge clk); #1;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step_cycles(1);
    do_reset(3);
    step_cycles(3);
    check_trunc();
    // coarse step: a few samples per period, exercises all quadrants
    load_tw((48'd37 << 36) + 48'd12345);
    step_cycles(300);
    check_no_load();
    // fine step: many samples per table slot
    load_tw((48'd3 << 34) + 48'd77);
    step_cycles(400);
    // reload mid-run, phase continuous (R3)
    load_tw(48'h7FFF_0000_1234);
    step_cycles(50);
    // negative-equivalent step, repeated wraps (R2)
    load_tw(48'hFFFF_FFFF_FFFF - (48'd5 << 36));
    step_cycles(200);
    // reset in the middle of a run (R1)
    do_reset(2);
    load_tw((48'd211 << 36) + 48'd999);
    step_cycles(300);
    // near-Nyquist step
    load_tw(48'h8000_0000_0001);
    step_cycles(100);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule